// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Buffer Memory

This block puts a single-port buffer memory behind a simple request port and protects each stored word with a Hamming code plus one overall parity bit. On a write it builds the codeword from the data and stores it. On a read it recomputes the syndrome and repairs any single flipped bit. It classifies the word as clean, carrying a repaired data-bit error, carrying a check-bit error, or uncorrectable. For each read response it reports that class and the syndrome, so a separate monitor can keep error counts.

The encoder and the decoder each have their own disable input. With the encoder off, the data is stored with all check bits and the parity bit at zero. With the decoder off, the stored data bits come back untouched and no error is reported. A word with an uncorrectable error is never handed out: the response carries a bus-error strobe and zero data in place of the valid strobe.

For fault simulation there is an injection path with two bit indices. While injection is enabled, each write flips the codeword bits the indices select before they reach the array. Equal indices flip one bit, different indices flip two bits, and an index beyond the codeword is ignored. With the default of 32 data bits and 2048 words (8 kB of data), a codeword is 39 bits wide.

Top module: `ecc_sram_wrap`

## Requirements
- R1: After a synchronous active-low reset, and in every cycle with no read response due, rd_valid and rd_bus_err are 0, rd_err_type is 00 and rd_syndrome is 0.
- R2: A read issued in cycle n answers in cycle n+1. For a word written with the encoder on, no injection and the decoder on, the response is rd_valid=1, rd_bus_err=0, the written data, rd_err_type=00 (none) and syndrome 0.
- R3: Codeword layout: bit 0 is the overall parity, which makes the whole codeword even. Positions 1..38 follow Hamming order, with check bits at the power-of-two positions. Data bit i sits at the i-th non-power-of-two position, so data bit 0 is at position 3 and data bit 1 is at position 5.
- R4: With one flipped data-bit position p, the read returns the corrected data with rd_valid=1, rd_err_type=01 and rd_syndrome=p.
- R5: With one flipped check bit at position 2^k, or a flipped parity bit 0, the data is returned intact with rd_err_type=10 and rd_syndrome equal to 2^k (0 for the parity bit).
- R6: Two flipped bits, or a syndrome that names no codeword position while parity is odd, give rd_valid=0, rd_bus_err=1, rd_data=0 and rd_err_type=11, with rd_syndrome equal to the XOR of the positions involved.
- R7: A read issued with dec_off=1 returns the stored data bits uncorrected, with rd_valid=1, rd_bus_err=0, rd_err_type=00 and syndrome 0, whatever faults the word carries.
- R8: A write with enc_off=1 stores all check bits and the parity bit as 0. A later read with the decoder on classifies that word by the rules of R4 to R6.
- R9: With inj_en=1, a write flips codeword bit inj_idx_a and, if it differs, bit inj_idx_b. An index of 39 or more flips nothing. With inj_en=0, nothing is flipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Word address |
| req_wdata | input | 32 | Write data |
| enc_off | input | 1 | Store without check bits |
| dec_off | input | 1 | Read without checking or correction |
| inj_en | input | 1 | Enable fault injection on writes |
| inj_idx_a | input | 6 | First codeword bit to flip |
| inj_idx_b | input | 6 | Second codeword bit to flip |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Corrected read data |
| rd_bus_err | output | 1 | Uncorrectable read, data withheld |
| rd_err_type | output | 2 | 00 none, 01 data single, 10 check single, 11 double |
| rd_syndrome | output | 6 | Syndrome of the read word |

## Verification
A write changes the array at the clock edge where it is sampled. The bench therefore starts a read no earlier than the edge after that. Every read result appears in the cycle after the edge that samples the request, and it stays until the next edge. The bench drives each request at a falling edge and compares all five response outputs at the next falling edge. It then releases the request and confirms at the falling edge after that that no response follows.

// File: rtl/ecc_pkg.sv
// Package: shared types and width helpers for the protected buffer memory.
// Assumes codeword positions are numbered from 0 (overall parity) upward.
package ecc_pkg;

    // Classification of a read word; the encoding is visible on rd_err_type.
    typedef enum logic [1:0] {
        ERR_NONE   = 2'b00,
        ERR_DATA   = 2'b01,
        ERR_CHECK  = 2'b10,
        ERR_DOUBLE = 2'b11
    } err_kind_e;

    // Smallest number of Hamming check bits p with 2^p >= data + p + 1.
    function automatic int ham_bits(input int data_w);
        int p;
        p = 1;
        while ((1 << p) < data_w + p + 1) p++;
        return p;
    endfunction

endpackage

// File: rtl/ecc_encoder.sv
// Module: ecc_encoder
// Builds a codeword from a data word. Data bits fill non-power-of-two
// positions in order; check bits sit at power-of-two positions; bit 0 is
// overall even parity. With enable low, check and parity bits are zero.
module ecc_encoder #(
    parameter int DATA_W = 32,
    parameter int HAM_W  = ecc_pkg::ham_bits(DATA_W),
    localparam int CW    = DATA_W + HAM_W + 1
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic              enable_i,
    output logic [CW-1:0]     cw_o
);

    logic [CW-1:0]    placed;
    logic [HAM_W-1:0] syn;

    // Place data bits and zero the check and parity positions.
    assign placed[0] = 1'b0;
    for (genvar p = 1; p < CW; p++) begin : g_place
        if ((p & (p - 1)) == 0) begin : g_chk
            assign placed[p] = 1'b0;
        end else begin : g_dat
            assign placed[p] = data_i[p - $clog2(p + 1) - 1];
        end
    end

    // Syndrome of the data-only vector gives the check-bit values.
    always_comb begin
        syn = '0;
        for (int p = 1; p < CW; p++) begin
            if (placed[p]) syn ^= HAM_W'(p);
        end
    end

    // Insert check bits, then overall parity over the whole word.
    always_comb begin
        cw_o = placed;
        if (enable_i) begin
            for (int k = 0; k < HAM_W; k++) begin
                cw_o[1 << k] = syn[k];
            end
            cw_o[0] = ^cw_o[CW-1:1];
        end
    end

endmodule

// File: rtl/ecc_fault_inject.sv
// Module: ecc_fault_inject
// Flips up to two codeword bits on the write path. Equal indices flip one
// bit; an index beyond the codeword has no effect.
module ecc_fault_inject #(
    parameter int CW    = 39,
    localparam int IDX_W = $clog2(CW)
) (
    input  logic [CW-1:0]    cw_i,
    input  logic             en_i,
    input  logic [IDX_W-1:0] idx_a_i,
    input  logic [IDX_W-1:0] idx_b_i,
    output logic [CW-1:0]    cw_o
);

    // Build flip mask from the two indices and apply it.
    always_comb begin
        cw_o = cw_i;
        if (en_i) begin
            for (int p = 0; p < CW; p++) begin
                if ((int'(idx_a_i) == p) || (int'(idx_b_i) == p && idx_b_i != idx_a_i)) begin
                    cw_o[p] = ~cw_i[p];
                end
            end
        end
    end

endmodule

// File: rtl/ecc_mem_array.sv
// Module: ecc_mem_array
// Behavioural single-port array with synchronous write and registered read.
// Assumes read and write are never requested in the same cycle.
module ecc_mem_array #(
    parameter int WIDTH = 39,
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic             re_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o
);

    logic [WIDTH-1:0] store [DEPTH];

    // Write the addressed word or capture it for a read.
    always_ff @(posedge clk) begin
        if (we_i) store[addr_i] <= wdata_i;
        if (re_i) rdata_o       <= store[addr_i];
    end

endmodule

// File: rtl/ecc_decoder.sv
// Module: ecc_decoder
// Checks a codeword, repairs a single flipped bit and classifies the word.
// With enable low it returns raw data bits and reports no error.
module ecc_decoder #(
    parameter int DATA_W = 32,
    parameter int HAM_W  = ecc_pkg::ham_bits(DATA_W),
    localparam int CW    = DATA_W + HAM_W + 1
) (
    input  logic [CW-1:0]      cw_i,
    input  logic               enable_i,
    output logic [DATA_W-1:0]  data_o,
    output ecc_pkg::err_kind_e kind_o,
    output logic [HAM_W-1:0]   syn_o
);

    logic [HAM_W-1:0] syn;
    logic             par_odd;
    logic [CW-1:0]    fixed;

    // Syndrome: XOR of the positions of all set bits above bit 0.
    always_comb begin
        syn = '0;
        for (int p = 1; p < CW; p++) begin
            if (cw_i[p]) syn ^= HAM_W'(p);
        end
        par_odd = ^cw_i;
    end

    // Classify the word and flip the bit the syndrome names.
    always_comb begin
        fixed  = cw_i;
        kind_o = ecc_pkg::ERR_NONE;
        syn_o  = '0;
        if (enable_i) begin
            syn_o = syn;
            if (par_odd) begin
                if (syn == '0 || (syn & (syn - 1'b1)) == '0) begin
                    kind_o = ecc_pkg::ERR_CHECK;
                end else if (int'(syn) < CW) begin
                    kind_o = ecc_pkg::ERR_DATA;
                    fixed[syn] = ~cw_i[syn];
                end else begin
                    kind_o = ecc_pkg::ERR_DOUBLE;
                end
            end else if (syn != '0) begin
                kind_o = ecc_pkg::ERR_DOUBLE;
            end
        end
    end

    // Pull data bits back out of their codeword positions.
    for (genvar p = 3; p < CW; p++) begin : g_ext
        if ((p & (p - 1)) != 0) begin : g_dat
            assign data_o[p - $clog2(p + 1) - 1] = fixed[p];
        end
    end

endmodule

// File: rtl/ecc_sram_wrap.sv
// Module: ecc_sram_wrap (top)
// Protected buffer memory: encode + optional fault injection on write,
// registered array read, decode and classification on the response cycle.
// Assumes one request per cycle; a read response is due one cycle later.
module ecc_sram_wrap #(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 2048,
    localparam int HAM_W  = ecc_pkg::ham_bits(DATA_W),
    localparam int CW     = DATA_W + HAM_W + 1,
    localparam int IDX_W  = $clog2(CW),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              enc_off,
    input  logic              dec_off,
    input  logic              inj_en,
    input  logic [IDX_W-1:0]  inj_idx_a,
    input  logic [IDX_W-1:0]  inj_idx_b,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_bus_err,
    output logic [1:0]        rd_err_type,
    output logic [HAM_W-1:0]  rd_syndrome
);

    logic [CW-1:0]      enc_cw;
    logic [CW-1:0]      wr_cw;
    logic [CW-1:0]      rd_cw;
    logic               rsp_pend;
    logic               rsp_dec_off;
    logic [DATA_W-1:0]  dec_data;
    ecc_pkg::err_kind_e dec_kind;
    logic [HAM_W-1:0]   dec_syn;
    logic               is_double;

    ecc_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc (
        .data_i   (req_wdata),
        .enable_i (!enc_off),
        .cw_o     (enc_cw)
    );

    ecc_fault_inject #(.CW(CW)) u_inj (
        .cw_i    (enc_cw),
        .en_i    (inj_en),
        .idx_a_i (inj_idx_a),
        .idx_b_i (inj_idx_b),
        .cw_o    (wr_cw)
    );

    ecc_mem_array #(.WIDTH(CW), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .we_i    (req_valid && req_write),
        .re_i    (req_valid && !req_write),
        .addr_i  (req_addr),
        .wdata_i (wr_cw),
        .rdata_o (rd_cw)
    );

    // Track which cycle carries a read response and its decoder setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_pend    <= 1'b0;
            rsp_dec_off <= 1'b0;
        end else begin
            rsp_pend    <= req_valid && !req_write;
            rsp_dec_off <= dec_off;
        end
    end

    ecc_decoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_dec (
        .cw_i     (rd_cw),
        .enable_i (!rsp_dec_off),
        .data_o   (dec_data),
        .kind_o   (dec_kind),
        .syn_o    (dec_syn)
    );

    assign is_double = (dec_kind == ecc_pkg::ERR_DOUBLE);

    // Drive the response, withholding data from uncorrectable words.
    always_comb begin
        rd_valid    = rsp_pend && !is_double;
        rd_bus_err  = rsp_pend && is_double;
        rd_data     = rd_valid ? dec_data : '0;
        rd_err_type = rsp_pend ? dec_kind : ecc_pkg::ERR_NONE;
        rd_syndrome = rsp_pend ? dec_syn : '0;
    end

endmodule

// File: rtl/ecc_sram_wrap_chk.sv
// Module: ecc_sram_wrap_chk
// Protocol checks on the top-level ports, attached by bind.
module ecc_sram_wrap_chk #(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 2048,
    localparam int HAM_W  = ecc_pkg::ham_bits(DATA_W),
    localparam int CW     = DATA_W + HAM_W + 1,
    localparam int IDX_W  = $clog2(CW),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              enc_off,
    input logic              dec_off,
    input logic              inj_en,
    input logic [IDX_W-1:0]  inj_idx_a,
    input logic [IDX_W-1:0]  inj_idx_b,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_bus_err,
    input logic [1:0]        rd_err_type,
    input logic [HAM_W-1:0]  rd_syndrome
);

    AST_READ_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (rd_valid || rd_bus_err)); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> (!rd_valid && !rd_bus_err && rd_err_type == 2'b00)); // R1
    AST_VALID_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_bus_err)); // R6
    AST_DOUBLE_WITHHELD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bus_err |-> (rd_data == '0 && rd_err_type == 2'b11)); // R6
    AST_DECODER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && dec_off) |=> (rd_valid && rd_err_type == 2'b00 && rd_syndrome == '0)); // R7

endmodule

bind ecc_sram_wrap ecc_sram_wrap_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/ecc_sram_wrap_test.sv
// Bench: directed corner cases plus seeded random traffic, checked against
// a reference codeword model written from the requirements.
module ecc_sram_wrap_test;

    localparam int PERIOD = 10;
    localparam int DW = 32;
    localparam int HW = 6;
    localparam int CW = 39;
    localparam int IW = 6;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_write, enc_off, dec_off, inj_en;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [IW-1:0] inj_idx_a, inj_idx_b;
    logic          rd_valid, rd_bus_err;
    logic [DW-1:0] rd_data;
    logic [1:0]    rd_err_type;
    logic [HW-1:0] rd_syndrome;

    int checks = 0;
    int fails  = 0;
    logic [CW-1:0] shadow [64];
    bit            written [64];

    always #(PERIOD/2) clk = ~clk;

    ecc_sram_wrap uut (.*);

    // Reference encoder per R3 and R8.
    function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d, input bit enc_on);
        logic [CW-1:0] cw = '0;
        logic [HW-1:0] s = '0;
        int i = 0;
        for (int p = 1; p < CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[i];
                i++;
            end
        end
        if (enc_on) begin
            for (int p = 1; p < CW; p++) if (cw[p]) s ^= HW'(p);
            for (int k = 0; k < HW; k++) cw[1 << k] = s[k];
            cw[0] = ^cw;
        end
        return cw;
    endfunction

    // Reference injection per R9.
    function automatic logic [CW-1:0] ref_inj(input logic [CW-1:0] cw, input bit en, input int a, input int b);
        if (en) begin
            if (a < CW) cw[a] = ~cw[a];
            if (b < CW && b != a) cw[b] = ~cw[b];
        end
        return cw;
    endfunction

    // Reference read response per R2, R4-R7: {valid, buserr, type, syn, data}.
    function automatic logic [DW+HW+3:0] ref_rsp(input logic [CW-1:0] cw, input bit dec_on);
        logic [HW-1:0] s = '0;
        logic [1:0]    t = 2'b00;
        logic [DW-1:0] d = '0;
        int i = 0;
        for (int p = 1; p < CW; p++) if (cw[p]) s ^= HW'(p);
        if (dec_on) begin
            if (^cw) begin
                if (s == 0 || (s & (s - 1)) == 0) t = 2'b10;
                else if (int'(s) < CW) begin t = 2'b01; cw[s] = ~cw[s]; end
                else t = 2'b11;
            end else if (s != 0) t = 2'b11;
        end else s = '0;
        for (int p = 1; p < CW; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[i] = cw[p];
                i++;
            end
        end
        if (t == 2'b11) return {1'b0, 1'b1, t, s, {DW{1'b0}}};
        return {1'b1, 1'b0, t, s, d};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        enc_off = 0; dec_off = 0; inj_en = 0; inj_idx_a = '0; inj_idx_b = '0;
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d, input bit eoff,
                            input bit ie, input int ia, input int ib);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = AW'(a); req_wdata = d;
        enc_off = eoff; inj_en = ie; inj_idx_a = IW'(ia); inj_idx_b = IW'(ib);
        shadow[a % 64] = ref_inj(ref_enc(d, !eoff), ie, ia, ib);
        written[a % 64] = 1;
        @(negedge clk);
        idle();
    endtask

    // Read and compare the whole response one cycle later.
    task automatic do_read(input int a, input bit doff, input string req);
        logic [DW+HW+3:0] exp, act;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = AW'(a); dec_off = doff;
        exp = ref_rsp(shadow[a % 64], !doff);
        @(negedge clk);
        idle();
        act = {rd_valid, rd_bus_err, rd_err_type, rd_syndrome, rd_data};
        check(act == exp, req, 64'(act), 64'(exp));
        @(negedge clk);
        act = {rd_valid, rd_bus_err, rd_err_type, rd_syndrome, rd_data};
        check(act == '0, "R1 idle after response", 64'(act), 64'd0);
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [DW+HW+3:0] exp;
        int seed;
        seed = 1234;
        void'($urandom(seed));
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check({rd_valid, rd_bus_err, rd_err_type, rd_syndrome} == '0, "R1 reset",
              64'({rd_valid, rd_bus_err, rd_err_type, rd_syndrome}), 64'd0);
        rst_n = 1;
        @(negedge clk);
        check({rd_valid, rd_bus_err, rd_err_type} == '0, "R1 after reset",
              64'({rd_valid, rd_bus_err, rd_err_type}), 64'd0);

        // R2 clean word at the top address.
        do_write(2047, 32'hDEAD_BEEF, 0, 0, 0, 0);
        do_read(2047, 0, "R2 clean read");
        // R4 data bit 0 lives at position 3 (R3): syndrome 3, data restored.
        do_write(1, 32'h0, 0, 1, 3, 3);
        exp = {1'b1, 1'b0, 2'b01, 6'd3, 32'h0};
        check(ref_rsp(shadow[1], 1) == exp, "R3 layout pos3", 64'(ref_rsp(shadow[1], 1)), 64'(exp));
        do_read(1, 0, "R4 data single");
        // R5 parity bit and check bit 8.
        do_write(2, 32'h1234_5678, 0, 1, 0, 0);
        do_read(2, 0, "R5 parity bit");
        do_write(3, 32'h0F0F_0F0F, 0, 1, 8, 8);
        do_read(3, 0, "R5 check bit 8");
        // R6 double: positions 3 and 5, syndrome 6.
        do_write(4, 32'h0, 0, 1, 3, 5);
        do_read(4, 0, "R6 double");
        // R7 decoder off on that double: raw data bits 0 and 1 set.
        do_read(4, 1, "R7 decoder off");
        // R8 encoder off, data 1: only position 3 set, repaired as data single.
        do_write(5, 32'h1, 1, 0, 0, 0);
        do_read(5, 0, "R8 encoder off");
        // R9 out-of-range index flips nothing.
        do_write(6, 32'hCAFE_F00D, 0, 1, 50, 63);
        do_read(6, 0, "R9 index out of range");
        do_write(7, 32'h5555_AAAA, 0, 0, 3, 5);
        do_read(7, 0, "R9 injection disabled");

        // Seeded random traffic.
        for (int n = 0; n < 600; n++) begin
            int a = int'($urandom_range(0, 63));
            if (!written[a] || $urandom_range(0, 1) == 0) begin
                int ia = int'($urandom_range(0, 40));
                int ib = ($urandom_range(0, 1) == 0) ? ia : int'($urandom_range(0, 40));
                do_write(a, $urandom(), $urandom_range(0, 7) == 0,
                         $urandom_range(0, 3) == 0, ia, ib);
            end else begin
                do_read(a, $urandom_range(0, 7) == 0, "R2 R4 R5 R6 R7 R8 R9 random read");
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule